// File: doc/BRIEF.md
# Clock-Source Control Register File

This block holds the software-visible settings of a clock-generation unit on an 8-bit register bus with a 3-bit offset. A write is taken on the rising clock edge when `wr_en` is high. Read data is combinational from `addr`, so a value written at one edge can be read in the cycle that follows. Each register applies its own write mask and read-back rule. Control and status always report their ready bits as set. The PLL source and multiplication factor are decoded and driven out to the clock tree. The oscillator clocks, the failure detector and the protection-key unlock logic are not part of this block. `prot_open` stands in for the unlock logic, and `fail_event` stands in for the failure detector.

Two small state machines carry the protected behaviour. The failure-detect lock has two states, DISARMED and ARMED. Its only transition, ARM, leaves DISARMED on a failure-register write with bit 0 set while `prot_open` is high. No transition leaves ARMED except reset. The PLL source selector holds one of three legal states: RC_LOW (code 0), RC_HIGH (code 2) and EXT (code 3). A PLL-control write with a legal code takes the SELECT transition to that state. A write with the illegal code 1 takes the REJECT transition, which keeps the current state and pulses `src_err`.

Top module: `clksrc_ctrl`

## Requirements
- R1: After reset every stored register is 0x00. Offsets 0 and 1 therefore read 0x30, every other offset reads 0x00, and `pll_src`, `pll_fac` and `src_err` are 0.
- R2: A write to offset 0 stores wdata & 0x1F into both the control and the status register. Reads of offset 0 and offset 1 return that stored value OR 0x30.
- R3: A write to offset 1 (status) or to offset 7 changes no register. Offset 7 always reads 0x00.
- R4: A write to offset 2 (external-oscillator control) stores wdata & 0xEF, and offset 2 reads the stored value.
- R5: Offset 4 (RC calibration) stores and reads back all 8 bits unchanged.
- R6: A write to offset 6 (DFLL control) keeps only bits 1:0 and clears the others.
- R7: Offset 3 reads {6'b0, fail flag in bit 1, detect enable in bit 0}. The detect enable is set only by a write to offset 3 with bit 0 = 1 while `prot_open` = 1.
- R8: Once the detect enable is set, no write clears it, whatever the value of `prot_open`.
- R9: The fail flag is set by `fail_event`. A write to offset 3 with bit 1 = 1 clears it, and bit 1 = 0 leaves it unchanged. When `fail_event` and a clearing write fall in the same cycle, the flag ends up set.
- R10: A write to offset 5 takes the PLL source from bits 7:6 and the factor from bits 4:0. Offset 5 reads {source, 1'b0, factor}, and `pll_src` and `pll_fac` show the same values.
- R11: A PLL write with source code 1 leaves the source unchanged but still updates the factor. In the cycle after that write, `src_err` is 1 for exactly one cycle. A write with a legal code leaves `src_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| prot_open | input | 1 | Protected-write window is open |
| fail_event | input | 1 | Oscillator-failure event from the detector |
| rdata | output | 8 | Read data for `addr` |
| pll_src | output | 2 | Decoded PLL source code |
| pll_fac | output | 5 | PLL multiplication factor |
| src_err | output | 1 | One-cycle pulse after a rejected source code |

## Verification
Two functions can fall in the same cycle: a failure event raising the fail flag, and a write-one clear of that flag. The bench provokes this by holding `fail_event` high during the same clock edge as a write of 0x02 to offset 3. It then judges the result by reading offset 3 and expecting bit 1 to still be set. The other registers are swept over all 256 write values, and the read-back is compared with the mask arithmetic stated in the requirements.

// File: rtl/clksrc_pkg.sv
`timescale 1ns/1ps
package clksrc_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int FAC_W  = 5;
    localparam int SRC_W  = 2;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_XOSC = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_FAIL = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_RCAL = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_PLL  = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_DFLL = 3'd6;

    localparam logic [DATA_W-1:0] CTRL_MASK  = 8'h1F;
    localparam logic [DATA_W-1:0] READY_BITS = 8'h30;
    localparam logic [DATA_W-1:0] XOSC_MASK  = 8'hEF;
    localparam logic [DATA_W-1:0] RCAL_MASK  = 8'hFF;
    localparam logic [DATA_W-1:0] DFLL_MASK  = 8'h03;

    typedef enum logic [0:0] {
        FD_DISARMED = 1'b0,
        FD_ARMED    = 1'b1
    } fd_state_e;

    typedef enum logic [SRC_W-1:0] {
        PSRC_RC_LOW  = 2'd0,
        PSRC_BAD     = 2'd1,
        PSRC_RC_HIGH = 2'd2,
        PSRC_EXT     = 2'd3
    } pll_src_e;
endpackage

// File: rtl/clksrc_masked_reg.sv
`timescale 1ns/1ps
module clksrc_masked_reg #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value_q <= '0;
        else if (wr_hit)
            value_q <= wdata & MASK;
    end

    assign value = value_q;
endmodule

// File: rtl/clksrc_fail_reg.sv
`timescale 1ns/1ps
module clksrc_fail_reg
    import clksrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_enable_bit,
    input  logic wr_clear_bit,
    input  logic prot_open,
    input  logic fail_event,
    output logic fd_en,
    output logic fail_flag
);
    fd_state_e state_q, state_n;
    logic      flag_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FD_DISARMED;
        else
            state_q <= state_n;
    end

    // transitions: ARM only; ARMED is left only by reset
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            FD_DISARMED:
                if (wr_hit && wr_enable_bit && prot_open)
                    state_n = FD_ARMED;
            FD_ARMED:
                state_n = FD_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        fd_en = 1'b0;
        unique case (state_q)
            FD_DISARMED: fd_en = 1'b0;
            FD_ARMED:    fd_en = 1'b1;
        endcase
    end

    // failure flag: event has priority over a write-one clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (fail_event)
            flag_q <= 1'b1;
        else if (wr_hit && wr_clear_bit)
            flag_q <= 1'b0;
    end

    assign fail_flag = flag_q;
endmodule

// File: rtl/clksrc_pll_reg.sv
`timescale 1ns/1ps
module clksrc_pll_reg
    import clksrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [SRC_W-1:0] wr_src,
    input  logic [FAC_W-1:0] wr_fac,
    output logic [SRC_W-1:0] src,
    output logic [FAC_W-1:0] fac,
    output logic             err
);
    pll_src_e         src_q, src_n;
    logic [FAC_W-1:0] fac_q;
    logic             err_q, reject;

    // state register for source, plus factor and error pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= PSRC_RC_LOW;
            fac_q <= '0;
            err_q <= 1'b0;
        end else begin
            src_q <= src_n;
            err_q <= reject;
            if (wr_hit)
                fac_q <= wr_fac;
        end
    end

    // SELECT / REJECT transitions
    always_comb begin
        src_n  = src_q;
        reject = 1'b0;
        if (wr_hit) begin
            unique case (wr_src)
                2'd0: src_n = PSRC_RC_LOW;
                2'd1: reject = 1'b1;
                2'd2: src_n = PSRC_RC_HIGH;
                2'd3: src_n = PSRC_EXT;
            endcase
        end
    end

    assign src = src_q;
    assign fac = fac_q;
    assign err = err_q;
endmodule

// File: rtl/clksrc_ctrl.sv
`timescale 1ns/1ps
module clksrc_ctrl
    import clksrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              prot_open,
    input  logic              fail_event,
    output logic [DATA_W-1:0] rdata,
    output logic [SRC_W-1:0]  pll_src,
    output logic [FAC_W-1:0]  pll_fac,
    output logic              src_err
);
    localparam int NPLAIN = 3;
    localparam logic [ADDR_W-1:0] PLAIN_OFF  [NPLAIN] = '{OFF_XOSC, OFF_RCAL, OFF_DFLL};
    localparam logic [DATA_W-1:0] PLAIN_MASK [NPLAIN] = '{XOSC_MASK, RCAL_MASK, DFLL_MASK};

    logic [DATA_W-1:0] plain_q [NPLAIN];
    logic [DATA_W-1:0] ctrl_q, stat_q;
    logic              fd_en, fail_flag;

    genvar gi;
    generate
        for (gi = 0; gi < NPLAIN; gi++) begin : g_plain
            clksrc_masked_reg #(.DATA_W(DATA_W), .MASK(PLAIN_MASK[gi])) u_reg (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_hit (wr_en && addr == PLAIN_OFF[gi]),
                .wdata  (wdata),
                .value  (plain_q[gi])
            );
        end
    endgenerate

    // control write mirrors into status; status offset itself is not writable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else if (wr_en && addr == OFF_CTRL) begin
            ctrl_q <= wdata & CTRL_MASK;
            stat_q <= wdata & CTRL_MASK;
        end
    end

    clksrc_fail_reg u_fail (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_hit        (wr_en && addr == OFF_FAIL),
        .wr_enable_bit (wdata[0]),
        .wr_clear_bit  (wdata[1]),
        .prot_open     (prot_open),
        .fail_event    (fail_event),
        .fd_en         (fd_en),
        .fail_flag     (fail_flag)
    );

    clksrc_pll_reg u_pll (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_en && addr == OFF_PLL),
        .wr_src (wdata[DATA_W-1 -: SRC_W]),
        .wr_fac (wdata[FAC_W-1:0]),
        .src    (pll_src),
        .fac    (pll_fac),
        .err    (src_err)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_CTRL: rdata = ctrl_q | READY_BITS;
            OFF_STAT: rdata = stat_q | READY_BITS;
            OFF_XOSC: rdata = plain_q[0];
            OFF_FAIL: rdata = {{(DATA_W-2){1'b0}}, fail_flag, fd_en};
            OFF_RCAL: rdata = plain_q[1];
            OFF_PLL:  rdata = {pll_src, {(DATA_W-SRC_W-FAC_W){1'b0}}, pll_fac};
            OFF_DFLL: rdata = plain_q[2];
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/clksrc_ctrl_chk.sv
`timescale 1ns/1ps
module clksrc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic       prot_open,
    input logic       fail_event,
    input logic [7:0] rdata,
    input logic [1:0] pll_src,
    input logic       src_err,
    input logic       fd_en,
    input logic       fail_flag
);
    // R2
    ready_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd0 || addr == 3'd1) |-> rdata[5:4] == 2'b11);

    // R7
    arm_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fd_en) |-> $past(wr_en && addr == 3'd3 && wdata[0] && prot_open));

    // R8
    enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fd_en |=> fd_en);

    // R9
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_event |=> fail_flag);

    // R11
    no_illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_src != 2'd1);

    // R11
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_err |-> $past(wr_en && addr == 3'd5 && wdata[7:6] == 2'd1));
endmodule

bind clksrc_ctrl clksrc_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .prot_open  (prot_open),
    .fail_event (fail_event),
    .rdata      (rdata),
    .pll_src    (pll_src),
    .src_err    (src_err),
    .fd_en      (fd_en),
    .fail_flag  (fail_flag)
);

// File: tb/clksrc_ctrl_bench.sv
`timescale 1ns/1ps
module clksrc_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       prot_open = 1'b0;
    logic       fail_event = 1'b0;
    logic [7:0] rdata;
    logic [1:0] pll_src;
    logic [4:0] pll_fac;
    logic       src_err;

    int checks = 0;
    int errors = 0;

    clksrc_ctrl u_clksrc_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .prot_open(prot_open), .fail_event(fail_event), .rdata(rdata),
        .pll_src(pll_src), .pll_fac(pll_fac), .src_err(src_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [1:0] src_m;
        logic [7:0] cur;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], r);
            chk("R1", r, (a < 2) ? 8'h30 : 8'h00);
        end
        chk("R1 src", {6'b0, pll_src}, 8'h00);
        chk("R1 fac", {3'b0, pll_fac}, 8'h00);
        chk("R1 err", {7'b0, src_err}, 8'h00);

        // R2 control sweep, R3 status write ignored
        for (int v = 0; v < 256; v++) begin
            wr(3'd0, v[7:0]);
            rd(3'd0, r); chk("R2 ctrl", r, (v[7:0] & 8'h1F) | 8'h30);
            rd(3'd1, r); chk("R2 stat", r, (v[7:0] & 8'h1F) | 8'h30);
            wr(3'd1, ~v[7:0]);
            rd(3'd1, r); chk("R3 stat", r, (v[7:0] & 8'h1F) | 8'h30);
            rd(3'd0, r); chk("R3 ctrl", r, (v[7:0] & 8'h1F) | 8'h30);
        end

        // R4, R5, R6 masked sweeps
        for (int v = 0; v < 256; v++) begin
            wr(3'd2, v[7:0]);
            rd(3'd2, r); chk("R4", r, v[7:0] & 8'hEF);
            wr(3'd4, v[7:0]);
            rd(3'd4, r); chk("R5", r, v[7:0]);
            wr(3'd6, v[7:0]);
            rd(3'd6, r); chk("R6", r, v[7:0] & 8'h03);
        end

        // R3 offset 7 writes touch nothing
        wr(3'd7, 8'hFF);
        rd(3'd7, r); chk("R3 off7", r, 8'h00);
        rd(3'd2, r); chk("R3 off7 xosc", r, 8'hEF);
        rd(3'd4, r); chk("R3 off7 rcal", r, 8'hFF);
        rd(3'd6, r); chk("R3 off7 dfll", r, 8'h03);

        // R10, R11 PLL sweep
        src_m = 2'd0;
        for (int v = 0; v < 256; v++) begin
            wr(3'd5, v[7:0]);
            if (v[7:6] != 2'd1) src_m = v[7:6];
            chk("R11 err pulse", {7'b0, src_err}, {7'b0, (v[7:6] == 2'd1)});
            chk("R10 src", {6'b0, pll_src}, {6'b0, src_m});
            chk("R10 fac", {3'b0, pll_fac}, {3'b0, v[4:0]});
            rd(3'd5, r); chk("R10 read", r, {src_m, 1'b0, v[4:0]});
            @(negedge clk);
            chk("R11 err one cycle", {7'b0, src_err}, 8'h00);
        end

        // R7 enable blocked while window closed
        prot_open = 1'b0;
        wr(3'd3, 8'h01);
        rd(3'd3, r); chk("R7 closed", r, 8'h00);
        // R9 event sets flag
        @(negedge clk); fail_event = 1'b1;
        @(negedge clk); fail_event = 1'b0;
        rd(3'd3, r); chk("R9 set", r, 8'h02);
        wr(3'd3, 8'h00);
        rd(3'd3, r); chk("R9 write0 keeps", r, 8'h02);
        wr(3'd3, 8'h02);
        rd(3'd3, r); chk("R9 write1 clears", r, 8'h00);
        // R9 event and clear in the same cycle
        @(negedge clk); fail_event = 1'b1;
        wr_en = 1'b1; addr = 3'd3; wdata = 8'h02;
        @(negedge clk); fail_event = 1'b0; wr_en = 1'b0;
        rd(3'd3, r); chk("R9 event wins", r, 8'h02);
        // R7 arm with window open
        prot_open = 1'b1;
        wr(3'd3, 8'h01);
        rd(3'd3, r); chk("R7 armed", r, 8'h03);
        // R8 sticky enable across all write values
        cur = 8'h03;
        for (int v = 0; v < 256; v++) begin
            prot_open = v[0];
            wr(3'd3, v[7:0]);
            if (v[1]) cur = 8'h01;
            rd(3'd3, r); chk("R8 sticky", r, cur);
        end
        prot_open = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule